// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one macrocell of a programmable logic block, together with the clock selection in front of it. It receives a sum-of-products term, an optional exclusive-OR operand, a second product term, four global clock pins, a product-term clock and three initialization terms. Configuration inputs decide three things. The first is whether the output is combinatorial, registered or latched. The second is which flip-flop type a single D storage bit imitates. The third is where its clock comes from, its output polarity and how the initialization terms map onto preset and reset.

All logic runs on one system clock `clk`. The global pins and the product-term clock are treated as sampled levels, and a clock event is the system cycle in which the selected level is first seen high after being seen low. A small block clock generator forms each of the four block clocks from one pin in true or complement form. The cell either uses one block clock together with the two block-wide initialization terms (synchronous mode), or it may also use the product-term clock with its own individual set/reset term (asynchronous mode). The storage bit is a two-state machine with states `ST_LOW` and `ST_HIGH`. Its transitions are `TR_HOLD` (stay), `TR_SET` (go to `ST_HIGH`), `TR_CLEAR` (go to `ST_LOW`) and `TR_TOGGLE` (go to the other state). Initialization terms take effect at the next `clk` edge whether or not a clock event occurs, and a clear beats a set.

Top module: `mc_cell`

## Requirements
- R1: The data term is P = sum_a XOR (xor_in AND cfg_xor_en). With cfg_out_mode 0 (combinatorial), or the unused code 3, mc_fb equals P and mc_out equals P XOR cfg_inv_out, with no clock involved. Mode code 1 is registered and code 2 is latched.
- R2: In registered and latched modes, mc_fb is the stored bit and mc_out is the stored bit XOR cfg_inv_out.
- R3: With cfg_reg_type 0 (D), a clock event loads P. The stored bit does not change while the selected clock stays high or stays low.
- R4: With cfg_reg_type 1 (T), a clock event toggles the bit when P is 1 and holds it when P is 0.
- R5: With cfg_reg_type 2 (JK), J is P and K is sum_b. On a clock event, J=0 K=0 holds, J=1 K=0 sets, J=0 K=1 clears, and J=1 K=1 toggles.
- R6: With cfg_reg_type 3 (SR), S is P and R is sum_b. On a clock event, S=1 R=0 sets, S=0 R=1 clears, and both 0 or both 1 hold.
- R7: Block clock k equals gclk[sel_k[1:0]] XOR sel_k[2], where sel_k is cfg_gen_sel[3k+2:3k]. cfg_bsel selects one block clock. A clock event is a rising edge of the selected block clock, and the stored bit updates at the `clk` edge that first samples the new high level. Edges on unselected pins have no effect.
- R8: When cfg_async=1 and cfg_use_pt=1, the clock is ptclk: its rising edge when cfg_pt_fall=0, its falling edge when cfg_pt_fall=1. In synchronous mode ptclk has no effect, even with cfg_use_pt=1.
- R9: With cfg_out_mode 2, the bit follows P while the selected clock level is high and holds while it is low.
- R10: In synchronous mode, bank_a is the preset term and bank_b the reset term when cfg_swap=0. The roles exchange when cfg_swap=1. Both act at the next `clk` edge, override any clock event and apply in every output mode. Reset wins when both are active. In asynchronous mode both bank terms are ignored.
- R11: In asynchronous mode cell_init presets the bit when cfg_cell_set=1 and resets it when cfg_cell_set=0. In synchronous mode cell_init is ignored.
- R12: While rst_n is low the bit is 0, so in registered mode mc_out equals cfg_inv_out. If the selected clock is already high at the first sample after reset is released, no clock event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and storage |
| rst_n | input | 1 | Active-low reset, clears the stored bit |
| sum_a | input | 1 | Main sum-of-products term |
| sum_b | input | 1 | Second term: K for JK, R for SR |
| xor_in | input | 1 | Exclusive-OR operand for the main term |
| gclk | input | NUM_GCLK | Global clock pins, sampled as levels |
| ptclk | input | 1 | Product-term clock |
| bank_a | input | 1 | Block-wide initialization term A |
| bank_b | input | 1 | Block-wide initialization term B |
| cell_init | input | 1 | Individual initialization term |
| cfg_out_mode | input | 2 | 0 combinatorial, 1 registered, 2 latched, 3 combinatorial |
| cfg_reg_type | input | 2 | 0 D, 1 T, 2 JK, 3 SR |
| cfg_xor_en | input | 1 | Enables xor_in onto the main term |
| cfg_inv_out | input | 1 | Inverts mc_out |
| cfg_async | input | 1 | 1 selects asynchronous mode |
| cfg_use_pt | input | 1 | Use ptclk as clock (asynchronous mode only) |
| cfg_pt_fall | input | 1 | Use the falling edge of ptclk |
| cfg_gen_sel | input | NUM_BCLK*(clog2(NUM_GCLK)+1) | Per block clock: pin index and invert bit |
| cfg_bsel | input | clog2(NUM_BCLK) | Chooses the block clock |
| cfg_swap | input | 1 | Exchanges the preset and reset roles of the bank terms |
| cfg_cell_set | input | 1 | cell_init presets (1) or resets (0) |
| mc_out | output | 1 | Macrocell output after polarity |
| mc_fb | output | 1 | Internal feedback, before polarity |

## Verification
The bench builds the cell with the default four global pins and four block clocks, so every block clock slot has a three-bit selector. It can therefore route the highest pin in complement form onto block clock 2 and show that a falling pin edge becomes a capturing edge while toggling the other pins has no effect. The same build reaches every register type, both product-term clock edges, the swap and priority cases of the bank terms, and cross-mode checks that one mode's initialization or clock input is ignored in the other mode.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        OM_COMB     = 2'd0,
        OM_REG      = 2'd1,
        OM_LATCH    = 2'd2,
        OM_COMB_ALT = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        RT_D  = 2'd0,
        RT_T  = 2'd1,
        RT_JK = 2'd2,
        RT_SR = 2'd3
    } reg_type_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } bit_state_e;

    typedef enum logic [1:0] {
        TR_HOLD   = 2'd0,
        TR_SET    = 2'd1,
        TR_CLEAR  = 2'd2,
        TR_TOGGLE = 2'd3
    } bit_action_e;

endpackage

// File: rtl/mc_clkgen.sv
module mc_clkgen #(
    parameter int NUM_GCLK = 4,
    parameter int NUM_BCLK = 4
) (
    input  logic [NUM_GCLK-1:0]                          gclk,
    input  logic [NUM_BCLK*($clog2(NUM_GCLK)+1)-1:0]     gen_sel,
    output logic [NUM_BCLK-1:0]                          bclk
);
    localparam int PINW = $clog2(NUM_GCLK);
    localparam int SELW = PINW + 1;

    for (genvar k = 0; k < NUM_BCLK; k++) begin : g_bclk
        logic [SELW-1:0] slot;
        assign slot    = gen_sel[k*SELW +: SELW];
        // each block clock: one pin, true or complement
        assign bclk[k] = gclk[slot[PINW-1:0]] ^ slot[SELW-1];
    end
endmodule

// File: rtl/mc_clksel.sv
module mc_clksel #(
    parameter int NUM_BCLK = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BCLK-1:0]          bclk,
    input  logic                         ptclk,
    input  logic                         use_async,
    input  logic                         use_pt,
    input  logic                         pt_fall,
    input  logic [$clog2(NUM_BCLK)-1:0]  bsel,
    output logic                         clk_evt,
    output logic                         gate_open
);
    logic lvl;
    logic lvl_q;

    always_comb begin
        if (use_async && use_pt) begin
            lvl = ptclk ^ pt_fall;
        end else begin
            lvl = bclk[bsel];
        end
    end

    // reset high so a clock already high after reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign clk_evt   = lvl & ~lvl_q;
    assign gate_open = lvl;
endmodule

// File: rtl/mc_initsel.sv
module mc_initsel (
    input  logic use_async,
    input  logic swap,
    input  logic cell_set,
    input  logic bank_a,
    input  logic bank_b,
    input  logic cell_init,
    output logic do_set,
    output logic do_clr
);
    always_comb begin
        if (use_async) begin
            do_set = cell_init &  cell_set;
            do_clr = cell_init & ~cell_set;
        end else if (swap) begin
            do_set = bank_b;
            do_clr = bank_a;
        end else begin
            do_set = bank_a;
            do_clr = bank_b;
        end
    end
endmodule

// File: rtl/mc_nextfn.sv
module mc_nextfn
    import mc_pkg::*;
(
    input  reg_type_e   rtype,
    input  logic        prim,
    input  logic        aux,
    output bit_action_e act
);
    always_comb begin
        unique case (rtype)
            RT_D:  act = prim ? TR_SET : TR_CLEAR;
            RT_T:  act = prim ? TR_TOGGLE : TR_HOLD;
            RT_JK: begin
                if (prim && aux)      act = TR_TOGGLE;
                else if (prim)        act = TR_SET;
                else if (aux)         act = TR_CLEAR;
                else                  act = TR_HOLD;
            end
            RT_SR: begin
                if (prim && !aux)     act = TR_SET;
                else if (!prim && aux) act = TR_CLEAR;
                else                  act = TR_HOLD;
            end
        endcase
    end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 4,
    parameter int NUM_BCLK = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       sum_a,
    input  logic                                       sum_b,
    input  logic                                       xor_in,
    input  logic [NUM_GCLK-1:0]                        gclk,
    input  logic                                       ptclk,
    input  logic                                       bank_a,
    input  logic                                       bank_b,
    input  logic                                       cell_init,
    input  logic [1:0]                                 cfg_out_mode,
    input  logic [1:0]                                 cfg_reg_type,
    input  logic                                       cfg_xor_en,
    input  logic                                       cfg_inv_out,
    input  logic                                       cfg_async,
    input  logic                                       cfg_use_pt,
    input  logic                                       cfg_pt_fall,
    input  logic [NUM_BCLK*($clog2(NUM_GCLK)+1)-1:0]   cfg_gen_sel,
    input  logic [$clog2(NUM_BCLK)-1:0]                cfg_bsel,
    input  logic                                       cfg_swap,
    input  logic                                       cfg_cell_set,
    output logic                                       mc_out,
    output logic                                       mc_fb
);
    logic [NUM_BCLK-1:0] bclk;
    logic                clk_evt;
    logic                gate_open;
    logic                do_set;
    logic                do_clr;
    logic                prim;
    bit_action_e         fn_act;
    bit_action_e         act;
    bit_state_e          state;
    bit_state_e          state_nx;
    out_mode_e           omode;

    assign prim  = sum_a ^ (xor_in & cfg_xor_en);
    assign omode = out_mode_e'(cfg_out_mode);

    mc_clkgen #(.NUM_GCLK(NUM_GCLK), .NUM_BCLK(NUM_BCLK)) i_clkgen (
        .gclk    (gclk),
        .gen_sel (cfg_gen_sel),
        .bclk    (bclk)
    );

    mc_clksel #(.NUM_BCLK(NUM_BCLK)) i_clksel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .ptclk     (ptclk),
        .use_async (cfg_async),
        .use_pt    (cfg_use_pt),
        .pt_fall   (cfg_pt_fall),
        .bsel      (cfg_bsel),
        .clk_evt   (clk_evt),
        .gate_open (gate_open)
    );

    mc_initsel i_initsel (
        .use_async (cfg_async),
        .swap      (cfg_swap),
        .cell_set  (cfg_cell_set),
        .bank_a    (bank_a),
        .bank_b    (bank_b),
        .cell_init (cell_init),
        .do_set    (do_set),
        .do_clr    (do_clr)
    );

    mc_nextfn i_nextfn (
        .rtype (reg_type_e'(cfg_reg_type)),
        .prim  (prim),
        .aux   (sum_b),
        .act   (fn_act)
    );

    // action arbitration: clear, then set, then clock/gate
    always_comb begin
        if (do_clr) begin
            act = TR_CLEAR;
        end else if (do_set) begin
            act = TR_SET;
        end else begin
            unique case (omode)
                OM_REG:   act = clk_evt ? fn_act : TR_HOLD;
                OM_LATCH: act = gate_open ? (prim ? TR_SET : TR_CLEAR) : TR_HOLD;
                default:  act = TR_HOLD;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_LOW:  state_nx = (act == TR_SET || act == TR_TOGGLE) ? ST_HIGH : ST_LOW;
            ST_HIGH: state_nx = (act == TR_CLEAR || act == TR_TOGGLE) ? ST_LOW : ST_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOW;
        end else begin
            state <= state_nx;
        end
    end

    // output process
    always_comb begin
        unique case (omode)
            OM_REG, OM_LATCH: mc_fb = (state == ST_HIGH);
            default:          mc_fb = prim;
        endcase
        mc_out = mc_fb ^ cfg_inv_out;
    end
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sum_a,
    input logic       xor_in,
    input logic       bank_a,
    input logic       bank_b,
    input logic       cell_init,
    input logic [1:0] cfg_out_mode,
    input logic [1:0] cfg_reg_type,
    input logic       cfg_xor_en,
    input logic       cfg_async,
    input logic       cfg_swap,
    input logic       cfg_cell_set,
    input logic       q,
    input logic       clk_evt
);
    logic init_any;
    logic p_term;
    assign init_any = cfg_async ? cell_init : (bank_a | bank_b);
    assign p_term   = sum_a ^ (cfg_xor_en & xor_in);

    assert_bank_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_async && (cfg_swap ? bank_a : bank_b)) |=> !q);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_async && bank_a && bank_b) |=> !q);

    assert_cell_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_async && cell_init && cfg_cell_set) |=> q);

    assert_cell_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_async && cell_init && !cfg_cell_set) |=> !q);

    assert_no_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_mode == 2'd1 && !clk_evt && !init_any) |=> $stable(q));

    assert_d_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_mode == 2'd1 && cfg_reg_type == 2'd0 && clk_evt && !init_any)
        |=> (q == $past(p_term)));

    assert_t_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_mode == 2'd1 && cfg_reg_type == 2'd1 && clk_evt && !init_any && p_term)
        |=> (q != $past(q)));
endmodule

bind mc_cell mc_cell_chk i_mc_cell_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sum_a        (sum_a),
    .xor_in       (xor_in),
    .bank_a       (bank_a),
    .bank_b       (bank_b),
    .cell_init    (cell_init),
    .cfg_out_mode (cfg_out_mode),
    .cfg_reg_type (cfg_reg_type),
    .cfg_xor_en   (cfg_xor_en),
    .cfg_async    (cfg_async),
    .cfg_swap     (cfg_swap),
    .cfg_cell_set (cfg_cell_set),
    .q            (state),
    .clk_evt      (clk_evt)
);

// File: tb/test_mc_cell.sv
module test_mc_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sum_a = 0, sum_b = 0, xor_in = 0;
    logic [3:0]  gclk = 4'b0000;
    logic        ptclk = 0, bank_a = 0, bank_b = 0, cell_init = 0;
    logic [1:0]  cfg_out_mode = 2'd1;
    logic [1:0]  cfg_reg_type = 2'd0;
    logic        cfg_xor_en = 0, cfg_inv_out = 0, cfg_async = 0;
    logic        cfg_use_pt = 0, cfg_pt_fall = 0;
    logic [11:0] cfg_gen_sel = 12'b011_010_001_000;
    logic [1:0]  cfg_bsel = 2'd0;
    logic        cfg_swap = 0, cfg_cell_set = 0;
    logic        mc_out, mc_fb;

    mc_cell i_mc_cell (
        .clk(clk), .rst_n(rst_n), .sum_a(sum_a), .sum_b(sum_b), .xor_in(xor_in),
        .gclk(gclk), .ptclk(ptclk), .bank_a(bank_a), .bank_b(bank_b),
        .cell_init(cell_init), .cfg_out_mode(cfg_out_mode),
        .cfg_reg_type(cfg_reg_type), .cfg_xor_en(cfg_xor_en),
        .cfg_inv_out(cfg_inv_out), .cfg_async(cfg_async),
        .cfg_use_pt(cfg_use_pt), .cfg_pt_fall(cfg_pt_fall),
        .cfg_gen_sel(cfg_gen_sel), .cfg_bsel(cfg_bsel), .cfg_swap(cfg_swap),
        .cfg_cell_set(cfg_cell_set), .mc_out(mc_out), .mc_fb(mc_fb)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic  o;
        logic  f;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    bit   reported = 0;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // driver: inputs already set at this negedge; expectation is for the next posedge
    task automatic expect_out(input logic o, input logic f, input string tag);
        exp_t e;
        e.o = o;
        e.f = f;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic edge0(input logic o, input logic f, input string tag);
        gclk[0] = 1'b1;
        expect_out(o, f, tag);
        gclk[0] = 1'b0;
        idle();
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (mc_out !== e.o || mc_fb !== e.f) begin
                    n_fail++;
                    $display("FAIL %s: out=%b fb=%b expected out=%b fb=%b",
                             e.tag, mc_out, mc_fb, e.o, e.f);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state, clock low
        sum_a = 1;
        expect_out(0, 0, "R12 bit low after reset");
        cfg_inv_out = 1;
        expect_out(1, 0, "R12 inverted output after reset");
        cfg_inv_out = 0;

        // R3 D type
        gclk[0] = 1;
        expect_out(1, 1, "R3 rising edge loads 1");
        sum_a = 0;
        expect_out(1, 1, "R3 clock held high no load");
        gclk[0] = 0;
        expect_out(1, 1, "R3 clock low no load");
        gclk[0] = 1;
        expect_out(0, 0, "R3 rising edge loads 0");
        gclk[0] = 0;
        idle();
        cfg_xor_en = 1; xor_in = 1;
        edge0(1, 1, "R3 xor operand flips data");
        cfg_xor_en = 0; xor_in = 0;
        cfg_inv_out = 1;
        expect_out(0, 1, "R2 inverted registered output");
        cfg_inv_out = 0;

        // R4 T type, bit = 1
        cfg_reg_type = 2'd1;
        sum_a = 1; edge0(0, 0, "R4 toggle to 0");
        sum_a = 0; edge0(0, 0, "R4 P=0 holds");
        sum_a = 1; edge0(1, 1, "R4 toggle to 1");

        // R5 JK, bit = 1
        cfg_reg_type = 2'd2;
        sum_a = 0; sum_b = 1; edge0(0, 0, "R5 K clears");
        sum_a = 1; sum_b = 0; edge0(1, 1, "R5 J sets");
        sum_a = 1; sum_b = 1; edge0(0, 0, "R5 J and K toggle");
        sum_a = 0; sum_b = 0; edge0(0, 0, "R5 neither holds");

        // R6 SR, bit = 0
        cfg_reg_type = 2'd3;
        sum_a = 1; sum_b = 0; edge0(1, 1, "R6 S sets");
        sum_a = 1; sum_b = 1; edge0(1, 1, "R6 S and R hold");
        sum_a = 0; sum_b = 1; edge0(0, 0, "R6 R clears");
        sum_a = 0; sum_b = 0; edge0(0, 0, "R6 neither holds");

        // R7 block clock 2 = complement of pin 3
        cfg_reg_type = 2'd0;
        cfg_gen_sel[8:6] = 3'b111;
        cfg_bsel = 2'd2;
        gclk[3] = 1; sum_a = 1;
        expect_out(0, 0, "R7 select change without edge");
        gclk[3] = 0;
        expect_out(1, 1, "R7 falling pin is rising block clock");
        sum_a = 0; gclk[0] = 1;
        expect_out(1, 1, "R7 unselected pin ignored");
        gclk[0] = 0; gclk[3] = 1;
        expect_out(1, 1, "R7 rising pin does not capture");

        // R8 product-term clock
        cfg_use_pt = 1; ptclk = 1;
        expect_out(1, 1, "R8 ptclk ignored in synchronous mode");
        ptclk = 0;
        idle();
        cfg_async = 1;
        expect_out(1, 1, "R8 enter async without edge");
        ptclk = 1;
        expect_out(0, 0, "R8 ptclk rising edge loads");
        cfg_pt_fall = 1; sum_a = 1;
        expect_out(0, 0, "R8 edge select change no load");
        ptclk = 0;
        expect_out(1, 1, "R8 ptclk falling edge loads");

        // R11 individual term
        cfg_cell_set = 0; cell_init = 1;
        expect_out(0, 0, "R11 individual reset");
        cell_init = 0; cfg_cell_set = 1;
        idle();
        cell_init = 1;
        expect_out(1, 1, "R11 individual preset");
        cell_init = 0; bank_b = 1;
        expect_out(1, 1, "R10 bank terms ignored in async mode");
        bank_b = 0;

        // R10 bank terms
        cfg_async = 0; cfg_use_pt = 0; cfg_bsel = 2'd0;
        expect_out(1, 1, "R10 back to sync without edge");
        bank_b = 1;
        expect_out(0, 0, "R10 bank_b resets");
        bank_b = 0; bank_a = 1;
        expect_out(1, 1, "R10 bank_a presets");
        bank_b = 1;
        expect_out(0, 0, "R10 reset wins over preset");
        bank_a = 0; bank_b = 0; cfg_swap = 1;
        idle();
        bank_b = 1;
        expect_out(1, 1, "R10 swapped bank_b presets");
        bank_b = 0; bank_a = 1;
        expect_out(0, 0, "R10 swapped bank_a resets");
        bank_a = 0; cfg_cell_set = 1; cell_init = 1;
        expect_out(0, 0, "R11 individual term ignored in sync mode");
        cell_init = 0; sum_a = 0; bank_b = 1; gclk[0] = 1;
        expect_out(1, 1, "R10 preset overrides clock edge");
        bank_b = 0; gclk[0] = 0; cfg_swap = 0;
        idle();

        // R9 latch, bit = 1
        cfg_out_mode = 2'd2; sum_a = 0;
        expect_out(1, 1, "R9 closed gate holds");
        gclk[0] = 1;
        expect_out(0, 0, "R9 open gate passes 0");
        sum_a = 1;
        expect_out(1, 1, "R9 open gate follows data");
        gclk[0] = 0; sum_a = 0;
        expect_out(1, 1, "R9 gate closes and holds");
        cfg_inv_out = 1;
        expect_out(0, 1, "R2 latched output inverted");

        // R1 combinatorial
        cfg_out_mode = 2'd0; sum_a = 1;
        expect_out(0, 1, "R1 comb inverted");
        cfg_inv_out = 0;
        expect_out(1, 1, "R1 comb true polarity");
        cfg_xor_en = 1; xor_in = 1;
        expect_out(0, 0, "R1 comb xor");
        cfg_out_mode = 2'd3; sum_a = 0;
        expect_out(1, 1, "R1 code 3 is combinatorial");

        repeat (3) @(negedge clk);
        done = 1;
        report();
        $finish;
    end
endmodule